// File: doc/BRIEF.md
# Bidirectional Stored-Path Bus Transceiver

This block joins an 18-bit card-side port (A) to an 18-bit backplane-side port (B) in both directions. Each direction has one storage word and four controls of its own: an active-low capture enable, a latch-level input, a sampled clock input and an active-low output enable. The capture enable gates every update. While it is low, a high latch level makes the path follow its input. A falling latch level freezes the word. A rising sampled clock loads the word while the latch level is low. While the capture enable is high, the word holds whatever the other controls do.

All logic runs in one clock domain `clk`. The latch level and the direction clock are sampled, and their edges are detected against the previous sample. Every output comes from a register, so a change at an input shows at the port one `clk` cycle later. The A side has three-state outputs: a data word and a per-bit drive enable. The B side has open-drain outputs: a per-bit pull-down request, so a stored 0 pulls the line low and a stored 1 releases it. An external pull-up resolves the B wire.

Top module: `bidir_xcvr18`

## Requirements
- R1: A synchronous active-high `rst` clears both stored words to zero and disables both output sides. After the reset edge, `a_drive` is all zeros and `b_pulldown` is all zeros.
- R2: With the capture enable low and the latch level high, the stored word takes the direction's input at every `clk` edge. It appears on the port one cycle later.
- R3: With the capture enable low, a latch level that was sampled 1 and is now sampled 0 stores the current input. After that, with the latch level low and no rising clock, the word holds while the input and the clock level change.
- R4: With the capture enable low and the latch level low, a direction clock that was sampled 0 and is now sampled 1 stores the input present at that sample.
- R5: With the capture enable high, the stored word holds. The direction clock and the latch level, including its falling edge, have no effect.
- R6: The A side drives when `ba_oe_n` was sampled low: `a_drive` is all ones and `a_out` carries the B-to-A word. When `ba_oe_n` was sampled high, `a_drive` is all zeros.
- R7: The B side is open-drain. When `ab_oe_n` was sampled low, `b_pulldown[i]` is 1 exactly where bit i of the A-to-B word is 0. When `ab_oe_n` was sampled high, `b_pulldown` is all zeros. With a pull-up, the wire then reads all ones.
- R8: The two directions are independent. The controls and data of one direction never change the word or the outputs of the other.
- R9: Edge history is kept even while the capture enable is high. A clock that rose during inhibit and is still high when the enable returns low does not load the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ab_cen_n | input | 1 | A-to-B capture enable, active low |
| ab_le | input | 1 | A-to-B latch level (high = transparent) |
| ab_clk | input | 1 | A-to-B sampled clock |
| ab_oe_n | input | 1 | B-side output enable, active low |
| ba_cen_n | input | 1 | B-to-A capture enable, active low |
| ba_le | input | 1 | B-to-A latch level (high = transparent) |
| ba_clk | input | 1 | B-to-A sampled clock |
| ba_oe_n | input | 1 | A-side output enable, active low |
| a_in | input | 18 | A-side data into the A-to-B path |
| a_out | output | 18 | A-side three-state data (B-to-A word) |
| a_drive | output | 18 | A-side per-bit drive enable |
| b_in | input | 18 | B-side data into the B-to-A path |
| b_pulldown | output | 18 | B-side open-drain pull-down request per bit |

## Verification
Two things can fall in the same cycle: a rising direction clock and an inhibiting capture enable. The bench raises the clock while the enable is high. It then drops the enable with the clock still high, and the resolved B wire must keep the old word. A separate step gives a rising clock together with a disabled output. The wire must read all ones, and once the enable returns, the word loaded on that edge must appear.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic cen_n;
    logic le;
    logic tck;
    logic oe_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  dir_ctrl_t    ctl,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         drive
);
  logic tck_rise, tck_fall_unused;
  logic le_rise_unused, le_fall;
  logic load;

  xcvr_edge u_tck_edge (
    .clk(clk), .rst(rst), .lvl(ctl.tck), .rise(tck_rise), .fall(tck_fall_unused)
  );
  xcvr_edge u_le_edge (
    .clk(clk), .rst(rst), .lvl(ctl.le), .rise(le_rise_unused), .fall(le_fall)
  );

  assign load = ~ctl.cen_n & (ctl.le | le_fall | tck_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      drive <= 1'b0;
    end else begin
      if (load) q <= d;
      drive <= ~ctl.oe_n;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (q == '0 && !drive));
  p_transparent_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctl.cen_n && ctl.le) |=> q == $past(d));
  p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctl.cen_n && !ctl.le && !le_fall && !tck_rise) |=> $stable(q));
  p_clock_load_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctl.cen_n && !ctl.le && tck_rise) |=> q == $past(d));
  p_inhibit_r5: assert property (@(posedge clk) disable iff (rst)
    ctl.cen_n |=> $stable(q));
  p_oe_follow_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drive == !$past(ctl.oe_n));
endmodule

// File: rtl/bidir_xcvr18.sv
module bidir_xcvr18
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ab_cen_n,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe_n,
  input  logic         ba_cen_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_drive,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_pulldown
);
  dir_ctrl_t    ab_ctl, ba_ctl;
  logic [W-1:0] ab_word, ba_word;
  logic         ab_drv, ba_drv;

  assign ab_ctl = '{cen_n: ab_cen_n, le: ab_le, tck: ab_clk, oe_n: ab_oe_n};
  assign ba_ctl = '{cen_n: ba_cen_n, le: ba_le, tck: ba_clk, oe_n: ba_oe_n};

  xcvr_lane #(.W(W)) u_ab (
    .clk(clk), .rst(rst), .ctl(ab_ctl), .d(a_in), .q(ab_word), .drive(ab_drv)
  );
  xcvr_lane #(.W(W)) u_ba (
    .clk(clk), .rst(rst), .ctl(ba_ctl), .d(b_in), .q(ba_word), .drive(ba_drv)
  );

  for (genvar i = 0; i < W; i++) begin : g_pins
    assign a_out[i]      = ba_word[i];
    assign a_drive[i]    = ba_drv;
    assign b_pulldown[i] = ab_drv & ~ab_word[i];
  end

  p_odrain_never_high_r7: assert property (@(posedge clk) disable iff (rst)
    (b_pulldown & ab_word) == '0);
  p_adrive_uniform_r6: assert property (@(posedge clk) disable iff (rst)
    (a_drive == '0) || (a_drive == '1));
endmodule

// File: tb/bidir_xcvr18_tb.sv
module bidir_xcvr18_tb;
  localparam int W = 18;
  localparam time CLK_PERIOD = 10;
  localparam int NV = 14;
  localparam logic [W-1:0] ONES = '1;

  // {cen_n, le, tck, oe_n, a_in, expected resolved B wire}
  localparam logic [4+2*W-1:0] VEC [NV] = '{
    {4'b0100, 18'h12345, 18'h12345},  // R2 transparent, R7 enabled
    {4'b0100, 18'h2ABCD, 18'h2ABCD},  // R2
    {4'b0000, 18'h01111, 18'h01111},  // R3 latch falling edge captures
    {4'b0000, 18'h3FFFF, 18'h01111},  // R3 held
    {4'b0010, 18'h0F0F0, 18'h0F0F0},  // R4 clock rise loads
    {4'b0010, 18'h00000, 18'h0F0F0},  // R3 clock high steady
    {4'b0000, 18'h00000, 18'h0F0F0},  // R3 clock falls, held
    {4'b1010, 18'h15555, 18'h0F0F0},  // R5 rise inhibited
    {4'b0010, 18'h15555, 18'h0F0F0},  // R9 enable returns, clock still high
    {4'b1100, 18'h2AAAA, 18'h0F0F0},  // R5 latch level ignored
    {4'b1000, 18'h2AAAA, 18'h0F0F0},  // R5 latch fall ignored
    {4'b0011, 18'h2AAAA, 18'h3FFFF},  // R7 loaded but released
    {4'b0000, 18'h00000, 18'h2AAAA},  // R7 enabled shows loaded word
    {4'b0100, 18'h00000, 18'h00000}   // R2
  };

  logic clk = 0, rst = 1;
  logic ab_cen_n = 0, ab_le = 0, ab_clk = 0, ab_oe_n = 1;
  logic ba_cen_n = 0, ba_le = 0, ba_clk = 0, ba_oe_n = 1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_drive, b_pulldown, b_wire;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign b_wire = ~b_pulldown;  // pull-up resolution

  bidir_xcvr18 #(.W(W)) u_dut (
    .clk(clk), .rst(rst),
    .ab_cen_n(ab_cen_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe_n(ab_oe_n),
    .ba_cen_n(ba_cen_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_pulldown(b_pulldown)
  );

  function automatic string vec_req(int i);
    case (i)
      2, 3, 5, 6: return "R3";
      4:          return "R4";
      7, 9, 10:   return "R5";
      8:          return "R9";
      11, 12:     return "R7";
      default:    return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    rst = 0;
    check("R1", a_drive, '0);
    check("R1", b_wire, ONES);

    for (int i = 0; i < NV; i++) begin
      {ab_cen_n, ab_le, ab_clk, ab_oe_n} = VEC[i][4+2*W-1:2*W];
      a_in = VEC[i][2*W-1:W];
      tick();
      check(vec_req(i), b_wire, VEC[i][W-1:0]);
    end
    // R8: A-to-B traffic never enabled the A side
    check("R8", a_drive, '0);

    // B-to-A: transparent with A side enabled (R2, R6)
    ba_le = 1; ba_oe_n = 0; b_in = 18'h3C3C3;
    tick();
    check("R6", a_drive, ONES);
    check("R2", a_out, 18'h3C3C3);
    // R8: B word held, A-to-B path busy must not touch it
    ba_le = 0; b_in = 18'h00001; tick();   // latch falling edge
    check("R3", a_out, 18'h00001);
    ab_le = 1; a_in = 18'h11111; b_in = 18'h22222; tick();
    check("R8", a_out, 18'h00001);
    check("R8", b_wire, 18'h11111);
    // B-to-A clocked load (R4)
    ba_clk = 1; b_in = 18'h2F00F; tick();
    check("R4", a_out, 18'h2F00F);
    // A side disable (R6)
    ba_oe_n = 1; tick();
    check("R6", a_drive, '0);

    // Reset mid-run clears words and releases outputs (R1)
    ba_oe_n = 0; ab_oe_n = 0; ab_le = 0; ba_clk = 0;
    rst = 1; tick();
    rst = 0;
    check("R1", a_drive, '0);
    check("R1", b_wire, ONES);
    tick();
    check("R1", a_out, '0);
    check("R1", b_wire, '0);   // enabled, word cleared to zero
    finish_run();
  end
endmodule